// File: doc/BRIEF.md
# Tick-Driven Real-Time Clock with Alarm

This block keeps wall-clock time for a chip that sleeps. A 47-bit count advances on each pulse of a 32 kHz tick enable. The upper 32 bits count whole seconds and the lower 15 bits count sub-second steps. A 47-bit alarm value is compared against the count, and a sticky alarm flag is raised when the count reaches it. Software reaches the block through a plain synchronous register bus with separate write and read strobes and one byte address. One level-sensitive interrupt line reports the enabled status conditions.

Writes to the time, alarm, control and status registers do not land at once. They are held in a single-entry slow path and applied on a later tick, which models a hand-off into an always-on domain. A done flag then reports that the write has landed, and reading the status register clears that flag. The interrupt-enable register is the exception: it is written at bus speed and never touches the done flag. The count also stays parked until software has written the seconds register at least once, so a fresh part does not run from an undefined time.

Top module: `slowclk_rtc`

## Requirements
- R1: After reset the status register (offset 0x14) reads 0x0000_0202: the invalid-state bit (bit 1) and the ready-for-next-write bit (bit 9) are set. Seconds (0x00) and fraction (0x04) read 0, alarm seconds (0x08) reads all ones, alarm fraction (0x0C) reads 0 and irq is low.
- R2: A write to offset 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 that arrives while no slow write is pending is accepted. It takes effect on the edge of the second tick after acceptance. From acceptance until that edge, status bit 10 (busy) is 1 and bit 9 (ready) is 0. On that edge, status bit 8 (done) is set.
- R3: Any read of offset 0x14 clears the done bit. If a commit lands on the same edge, the commit wins.
- R4: A write to a slow-path offset that arrives while a commit is pending is discarded and sets status bit 7 (write error).
- R5: A write to offset 0x18 (interrupt enable) takes effect on the next edge and does not set the done bit. Only bits 9, 8, 7 and 4 are stored; all other bits read 0.
- R6: The count does not advance on ticks until the seconds register has been committed at least once, even with the run bit set.
- R7: With control bit 3 (run) set and the count armed, each tick adds one to the 47-bit {seconds, fraction} count, carrying from the fraction into the seconds. The value of the run bit before a commit edge decides whether that edge counts.
- R8: A committed seconds write loads the upper count bits. A committed fraction write loads the fraction from the low bits of the data, and the fraction register reads back with every higher bit at 0. A load takes priority over a tick on the same edge.
- R9: Status bit 4 (alarm) is set when the count steps or is loaded onto a value equal to {alarm seconds, alarm fraction}. It stays set until it is cleared.
- R10: A committed write to the status register clears bit 7, bit 4 and bit 1 where the data has a 1. Bit 0 (security violation) always reads 0.
- R11: irq is high exactly when some status bit among 9, 8, 7 and 4 is set and its matching bit in the interrupt-enable register is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 32 kHz time-step enable |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for read side effects) |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request, OR of the enabled status bits |

## Verification
The bench builds the block with FRAC_W set to 4 and every other parameter at its default. With that setting a seconds carry arrives after only sixteen ticks, so the bench reaches a fraction rollover into the seconds field in a short run. It also makes the fraction read-back masking visible with ordinary data patterns. The default two-tick commit delay is kept. This lets the bench place ticks between acceptance and commit, which exercises the dropped-write error and the rule that the old run bit applies on the commit edge.

// File: rtl/slowclk_rtc_pkg.sv
package slowclk_rtc_pkg;
   // register byte offsets
   localparam logic [4:0] OFS_SEC   = 5'h00;
   localparam logic [4:0] OFS_FRAC  = 5'h04;
   localparam logic [4:0] OFS_ASEC  = 5'h08;
   localparam logic [4:0] OFS_AFRAC = 5'h0C;
   localparam logic [4:0] OFS_CTRL  = 5'h10;
   localparam logic [4:0] OFS_STAT  = 5'h14;
   localparam logic [4:0] OFS_IEN   = 5'h18;

   // status / enable bit positions
   localparam int ST_BUSY = 10;
   localparam int ST_NEXT = 9;
   localparam int ST_DONE = 8;
   localparam int ST_ERR  = 7;
   localparam int ST_ALM  = 4;
   localparam int ST_NV   = 1;
   localparam int ST_SV   = 0;
   localparam int CTRL_RUN = 3;

   typedef enum logic [2:0] {
      TGT_SEC, TGT_FRAC, TGT_ASEC, TGT_AFRAC, TGT_CTRL, TGT_STAT
   } slow_tgt_e;
endpackage

// File: rtl/slowclk_rtc_commit.sv
// Single-entry slow-path write holder: commits on the Nth tick after accept.
module slowclk_rtc_commit
   import slowclk_rtc_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int COMMIT_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              req,
   input  slow_tgt_e         req_tgt,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              commit,
   output slow_tgt_e         commit_tgt,
   output logic [DATA_W-1:0] commit_data,
   output logic              drop
);
   logic      pend_q;
   slow_tgt_e tgt_q;
   logic [DATA_W-1:0] data_q;
   logic      last_tick;
   logic      accept;

   assign accept = req && !pend_q;
   assign drop   = req && pend_q;

   generate
      if (COMMIT_TICKS < 1) begin : g_bad
         $error("COMMIT_TICKS must be at least 1");
      end
      if (COMMIT_TICKS == 1) begin : g_one
         assign last_tick = pend_q && tick;
      end else begin : g_cnt
         localparam int CW = $clog2(COMMIT_TICKS);
         logic [CW-1:0] seen_q;
         assign last_tick = pend_q && tick && (seen_q == CW'(COMMIT_TICKS - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              seen_q <= '0;
            else if (accept)         seen_q <= '0;
            else if (pend_q && tick) seen_q <= seen_q + CW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         tgt_q  <= TGT_CTRL;
         data_q <= '0;
      end else if (accept) begin
         pend_q <= 1'b1;
         tgt_q  <= req_tgt;
         data_q <= req_data;
      end else if (last_tick) begin
         pend_q <= 1'b0;
      end
   end

   assign busy        = pend_q;
   assign commit      = last_tick;
   assign commit_tgt  = tgt_q;
   assign commit_data = data_q;
endmodule

// File: rtl/slowclk_rtc_timer.sv
// 47-bit (by default) time count with arming, loads and alarm match.
module slowclk_rtc_timer #(
   parameter int DATA_W = 32,
   parameter int SEC_W  = 32,
   parameter int FRAC_W = 15,
   localparam int CNT_W = SEC_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run_en,
   input  logic              ld_sec,
   input  logic              ld_frac,
   input  logic [DATA_W-1:0] ld_val,
   input  logic [CNT_W-1:0]  alarm_val,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              armed_q,
   output logic              hit
);
   logic             step;
   logic [CNT_W-1:0] cnt_d;

   assign step = tick && run_en && armed_q;

   always_comb begin
      if (ld_sec)       cnt_d = {ld_val[SEC_W-1:0], cnt_q[FRAC_W-1:0]};
      else if (ld_frac) cnt_d = {cnt_q[CNT_W-1:FRAC_W], ld_val[FRAC_W-1:0]};
      else if (step)    cnt_d = cnt_q + CNT_W'(1);
      else              cnt_d = cnt_q;
   end

   assign hit = (ld_sec || ld_frac || step) && (cnt_d == alarm_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (ld_sec) armed_q <= 1'b1;
      end
   end
endmodule

// File: rtl/slowclk_rtc_flags.sv
// Sticky status flags and status word assembly.
module slowclk_rtc_flags
   import slowclk_rtc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              stat_rd,
   input  logic              commit,
   input  logic              stat_wr,
   input  logic              clr_err,
   input  logic              clr_alm,
   input  logic              clr_nv,
   input  logic              drop,
   input  logic              alarm_hit,
   output logic [DATA_W-1:0] status
);
   logic done_q, err_q, alm_q, nv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         alm_q  <= 1'b0;
         nv_q   <= 1'b1;
      end else begin
         if (commit)       done_q <= 1'b1;
         else if (stat_rd) done_q <= 1'b0;

         if (drop)                    err_q <= 1'b1;
         else if (stat_wr && clr_err) err_q <= 1'b0;

         if (alarm_hit)               alm_q <= 1'b1;
         else if (stat_wr && clr_alm) alm_q <= 1'b0;

         if (stat_wr && clr_nv) nv_q <= 1'b0;
      end
   end

   always_comb begin
      status          = '0;
      status[ST_BUSY] = busy;
      status[ST_NEXT] = !busy;
      status[ST_DONE] = done_q;
      status[ST_ERR]  = err_q;
      status[ST_ALM]  = alm_q;
      status[ST_NV]   = nv_q;
      status[ST_SV]   = 1'b0;
   end
endmodule

// File: rtl/slowclk_rtc.sv
module slowclk_rtc
   import slowclk_rtc_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int SEC_W        = 32,
   parameter int FRAC_W       = 15,
   parameter int COMMIT_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int CNT_W = SEC_W + FRAC_W;
   localparam logic [DATA_W-1:0] IEN_MASK =
      (DATA_W'(1) << ST_NEXT) | (DATA_W'(1) << ST_DONE) |
      (DATA_W'(1) << ST_ERR)  | (DATA_W'(1) << ST_ALM);

   generate
      if (ADDR_W < 5)          begin : g_e0 $error("ADDR_W too small");   end
      if (DATA_W < 16)         begin : g_e1 $error("DATA_W too small");   end
      if (SEC_W > DATA_W)      begin : g_e2 $error("SEC_W > DATA_W");     end
      if (FRAC_W >= DATA_W)    begin : g_e3 $error("FRAC_W >= DATA_W");   end
      if (FRAC_W < 1)          begin : g_e4 $error("FRAC_W must be >0");  end
   endgenerate

   // address decode
   logic a_sec, a_frac, a_asec, a_afrac, a_ctrl, a_stat, a_ien;
   assign a_sec   = bus_addr == ADDR_W'(OFS_SEC);
   assign a_frac  = bus_addr == ADDR_W'(OFS_FRAC);
   assign a_asec  = bus_addr == ADDR_W'(OFS_ASEC);
   assign a_afrac = bus_addr == ADDR_W'(OFS_AFRAC);
   assign a_ctrl  = bus_addr == ADDR_W'(OFS_CTRL);
   assign a_stat  = bus_addr == ADDR_W'(OFS_STAT);
   assign a_ien   = bus_addr == ADDR_W'(OFS_IEN);

   logic      slow_req;
   slow_tgt_e req_tgt;
   assign slow_req = bus_wr && (a_sec || a_frac || a_asec || a_afrac || a_ctrl || a_stat);

   always_comb begin
      if (a_sec)        req_tgt = TGT_SEC;
      else if (a_frac)  req_tgt = TGT_FRAC;
      else if (a_asec)  req_tgt = TGT_ASEC;
      else if (a_afrac) req_tgt = TGT_AFRAC;
      else if (a_stat)  req_tgt = TGT_STAT;
      else              req_tgt = TGT_CTRL;
   end

   // slow path
   logic              busy, commit, drop;
   slow_tgt_e         commit_tgt;
   logic [DATA_W-1:0] commit_data;

   slowclk_rtc_commit #(.DATA_W(DATA_W), .COMMIT_TICKS(COMMIT_TICKS)) u_commit (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .req(slow_req), .req_tgt(req_tgt), .req_data(bus_wdata),
      .busy(busy), .commit(commit), .commit_tgt(commit_tgt),
      .commit_data(commit_data), .drop(drop)
   );

   logic cm_sec, cm_frac, cm_asec, cm_afrac, cm_ctrl, cm_stat;
   assign cm_sec   = commit && (commit_tgt == TGT_SEC);
   assign cm_frac  = commit && (commit_tgt == TGT_FRAC);
   assign cm_asec  = commit && (commit_tgt == TGT_ASEC);
   assign cm_afrac = commit && (commit_tgt == TGT_AFRAC);
   assign cm_ctrl  = commit && (commit_tgt == TGT_CTRL);
   assign cm_stat  = commit && (commit_tgt == TGT_STAT);

   // configuration registers
   logic [DATA_W-1:0] ctrl_q, ien_q;
   logic [SEC_W-1:0]  asec_q;
   logic [FRAC_W-1:0] afrac_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         ien_q   <= '0;
         asec_q  <= '1;
         afrac_q <= '0;
      end else begin
         if (cm_ctrl)           ctrl_q  <= commit_data;
         if (cm_asec)           asec_q  <= commit_data[SEC_W-1:0];
         if (cm_afrac)          afrac_q <= commit_data[FRAC_W-1:0];
         if (bus_wr && a_ien)   ien_q   <= bus_wdata & IEN_MASK;
      end
   end

   // time count
   logic [CNT_W-1:0] cnt_q;
   logic             armed, alarm_hit;

   slowclk_rtc_timer #(.DATA_W(DATA_W), .SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(ctrl_q[CTRL_RUN]),
      .ld_sec(cm_sec), .ld_frac(cm_frac), .ld_val(commit_data),
      .alarm_val({asec_q, afrac_q}), .cnt_q(cnt_q), .armed_q(armed),
      .hit(alarm_hit)
   );

   // status
   logic [DATA_W-1:0] status;
   slowclk_rtc_flags #(.DATA_W(DATA_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .busy(busy),
      .stat_rd(bus_rd && a_stat), .commit(commit), .stat_wr(cm_stat),
      .clr_err(commit_data[ST_ERR]), .clr_alm(commit_data[ST_ALM]),
      .clr_nv(commit_data[ST_NV]), .drop(drop), .alarm_hit(alarm_hit),
      .status(status)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (a_sec)        bus_rdata = DATA_W'(cnt_q[CNT_W-1:FRAC_W]);
      else if (a_frac)  bus_rdata = DATA_W'(cnt_q[FRAC_W-1:0]);
      else if (a_asec)  bus_rdata = DATA_W'(asec_q);
      else if (a_afrac) bus_rdata = DATA_W'(afrac_q);
      else if (a_ctrl)  bus_rdata = ctrl_q;
      else if (a_stat)  bus_rdata = status;
      else if (a_ien)   bus_rdata = ien_q;
   end

   assign irq = |(status & ien_q);
endmodule

// File: rtl/slowclk_rtc_chk.sv
module slowclk_rtc_chk
   import slowclk_rtc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 47
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              slow_req,
   input logic              busy,
   input logic              commit,
   input logic              armed,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [DATA_W-1:0] status,
   input logic [DATA_W-1:0] ien_q,
   input logic              irq
);
   localparam logic [DATA_W-1:0] MSK =
      (DATA_W'(1) << ST_NEXT) | (DATA_W'(1) << ST_DONE) |
      (DATA_W'(1) << ST_ERR)  | (DATA_W'(1) << ST_ALM);

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      slow_req && !busy |=> status[ST_BUSY] && !status[ST_NEXT]);

   p_commit_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> status[ST_DONE] && !status[ST_BUSY]);

   p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == ADDR_W'(OFS_STAT) && !commit |=> !status[ST_DONE]);

   p_drop_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
      slow_req && busy |=> status[ST_ERR]);

   p_ien_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(OFS_IEN) |=> ien_q == ($past(bus_wdata) & MSK));

   p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !armed && !commit |=> $stable(cnt_q));

   p_alarm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_ALM] && !commit |=> status[ST_ALM]);

   p_irq_alarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_ALM]) && ien_q[ST_ALM] |-> irq);
endmodule

bind slowclk_rtc slowclk_rtc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .slow_req(slow_req),
   .busy(busy), .commit(commit), .armed(armed), .cnt_q(cnt_q),
   .status(status), .ien_q(ien_q), .irq(irq)
);

// File: tb/sim_slowclk_rtc.sv
`timescale 1ns/1ps
module sim_slowclk_rtc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int vecs = 0;
   int bad  = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   slowclk_rtc #(.FRAC_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // monitor: compares read data against the scoreboard
   always @(negedge clk) begin
      #3;
      if (bus_rd && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         vecs++;
         if (bus_rdata !== e) begin
            bad++;
            $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk); #3;
      vecs++;
      if (irq !== e) begin
         bad++;
         $display("FAIL %s: irq got %b expected %b", t, irq, e);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h14, 32'h202, "R1 status");
      rd(8'h00, 32'h0, "R1 seconds");
      rd(8'h04, 32'h0, "R1 fraction");
      rd(8'h08, 32'hFFFF_FFFF, "R1 alarm seconds");
      rd(8'h0C, 32'h0, "R1 alarm fraction");
      chk_irq(1'b0, "R1 irq");

      // R2 control write through slow path
      wr(8'h10, 32'h8);
      rd(8'h14, 32'h402, "R2 busy while pending");
      ticks(1);
      rd(8'h10, 32'h0, "R2 not yet committed");
      ticks(1);
      rd(8'h10, 32'h8, "R2 committed control");
      rd(8'h14, 32'h302, "R2 done set");
      rd(8'h14, 32'h202, "R3 done cleared by read");

      // R6 frozen before seconds written
      ticks(5);
      rd(8'h04, 32'h0, "R6 frozen fraction");

      // R8 seconds load, R7 counting and carry
      wr(8'h00, 32'd5);
      ticks(2);
      rd(8'h14, 32'h302, "R2 seconds commit");
      rd(8'h04, 32'h0, "R8 load beats tick");
      ticks(3);
      rd(8'h00, 32'd5, "R7 seconds");
      rd(8'h04, 32'd3, "R7 fraction count");
      ticks(13);
      rd(8'h00, 32'd6, "R7 carry into seconds");
      rd(8'h04, 32'd0, "R7 fraction wrap");

      // R7 run bit cleared; old value used on commit edge
      wr(8'h10, 32'h0);
      ticks(2);
      ticks(4);
      rd(8'h04, 32'd2, "R7 stopped after commit");
      rd(8'h14, 32'h302, "R2 control commit");

      // R8 fraction load and masking
      wr(8'h04, 32'hFFFF_FFF7);
      ticks(2);
      rd(8'h04, 32'd7, "R8 fraction masked");
      rd(8'h00, 32'd6, "R8 seconds kept");
      rd(8'h14, 32'h302, "R2 fraction commit");

      // R5 interrupt enable at bus speed
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, 32'h390, "R5 enable mask");
      chk_irq(1'b1, "R11 ready bit enabled");
      wr(8'h18, 32'h100);
      rd(8'h14, 32'h202, "R5 no done flag");
      chk_irq(1'b0, "R11 done clear");

      // R4 write while pending
      wr(8'h08, 32'd6);
      wr(8'h0C, 32'd9);
      rd(8'h14, 32'h482, "R4 error and busy");
      ticks(2);
      chk_irq(1'b1, "R11 done enabled");
      rd(8'h14, 32'h382, "R4 done with error");
      chk_irq(1'b0, "R11 error not enabled");
      rd(8'h0C, 32'h0, "R4 dropped write absent");
      rd(8'h08, 32'd6, "R2 alarm seconds");
      wr(8'h14, 32'h80);
      ticks(2);
      rd(8'h14, 32'h302, "R10 error cleared");
      rd(8'h14, 32'h202, "R3 read clear");

      // R9 alarm
      wr(8'h0C, 32'd10);
      ticks(2);
      wr(8'h10, 32'h8);
      ticks(2);
      rd(8'h04, 32'd7, "R7 no count on enabling edge");
      rd(8'h14, 32'h302, "R2 ctrl commit");
      wr(8'h18, 32'h10);
      ticks(2);
      rd(8'h14, 32'h202, "R9 no early alarm");
      chk_irq(1'b0, "R11 before alarm");
      ticks(1);
      rd(8'h14, 32'h212, "R9 alarm set");
      chk_irq(1'b1, "R11 alarm irq");
      ticks(2);
      rd(8'h14, 32'h212, "R9 alarm sticky");
      wr(8'h14, 32'h10);
      ticks(2);
      rd(8'h14, 32'h302, "R10 alarm cleared");
      chk_irq(1'b0, "R11 after alarm clear");
      rd(8'h04, 32'd14, "R7 kept counting");

      // R10 invalid-state clear
      wr(8'h14, 32'h2);
      ticks(2);
      rd(8'h14, 32'h300, "R10 invalid cleared");
      rd(8'h14, 32'h200, "R10 stays clear");

      // R11 ready bit as interrupt
      wr(8'h18, 32'h200);
      chk_irq(1'b1, "R11 ready idle");
      wr(8'h10, 32'h8);
      chk_irq(1'b0, "R11 ready low while busy");
      ticks(2);
      chk_irq(1'b1, "R11 ready after commit");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end
endmodule